// File: doc/BRIEF.md
# Split-Mode Performance Counter Bank

This block holds four physical event counters reached through a small register interface. Each physical counter runs either as one 32-bit counter or as two independent 16-bit counters, so the bank offers eight logical counters. Logical counters 0 to 3 sit in the upper halves of physical counters 0 to 3. Logical counters 4 to 7 sit in the lower halves of the same physical counters. When a physical counter is in 32-bit mode, both of its logical addresses reach the whole counter.

Software does not write a running counter directly. A counter write fills a per-counter holding register. The live counters take their new values only when the global control word is written with its run bit set. That write loads every holding register at once and starts counting. Clearing the run bit freezes all counters. Eight plain control words, one for each logical counter, sit beside the global control word for the event-selection logic that lies outside this block.

Top module: `pcb_top`

## Requirements
- R1: After a synchronous active-high reset, every register in the bank reads zero: the global control word, all eight counter views, and all eight per-counter control words.
- R2: In 32-bit mode, physical counter p (0 to 3) adds one on every cycle that `event_in[p]` is high while the run bit is set. It wraps from 0xFFFFFFFF to 0. `event_in[p+4]` has no effect on it.
- R3: In 16-bit mode, the upper half of physical counter p counts `event_in[p]` and the lower half counts `event_in[p+4]`. Each half wraps from 0xFFFF to 0 without carrying into the other half.
- R4: A counter write made while the run bit is clear goes only to that counter's holding register and marks it pending. A read of a pending counter returns the holding value.
- R5: A write to the global control word with bit 0 set copies all four holding registers into the live counters and clears every pending mark. Counting resumes on the following cycle. Counters never written since reset are reloaded with zero.
- R6: While bit 0 of the global control word is clear, no live counter changes.
- R7: Bit 1+p of the global control word puts physical counter p in 16-bit mode. In that mode, logical counter p reads the upper half zero-extended and logical counter p+4 reads the lower half. A write to either one replaces only its own half of the holding register and keeps the other half from the counter's current view.
- R8: Registers are 32 bits wide and travel in bits 63:32 of the 64-bit bus. Bits 31:0 are ignored on write and read as zero. The map is: global control at address 0, logical counter l at address 8+l, per-counter control word l at address 16+l. The global control word reads back its run and size bits.
- R9: Each of the eight per-counter control words stores a written 32-bit value and reads it back.
- R10: A counter write made while running updates the holding register without marking it pending. Reads keep showing the live count until the next commit.
- R11: Addresses outside the map read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 64 | Write data, value in bits 63:32 |
| reg_rdata | output | 64 | Read data for `reg_addr`, combinational, value in bits 63:32 |
| event_in | input | 8 | One event pulse per logical counter |

## Verification
The bench builds the bank with its default of four physical counters, which gives eight logical counters and a 5-bit address. At this size every split, merge and mapping case is reachable with a handful of writes. Preloading 0xFFFF into a lower half and 0xFFFFFFFF into a whole counter brings both wrap boundaries within one event cycle, so no long count runs are needed. The scenario also shows the side effect of a commit that reloads every counter: a rewrite of the control word sends a running counter back to its stale holding value.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

    localparam int REG_W    = 32;
    localparam int HALF_W   = REG_W / 2;
    localparam int RUN_BIT  = 0;
    localparam int HALF_LSB = 1;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_GLOBAL,
        SEL_COUNTER,
        SEL_EVCTL
    } sel_kind_e;

    // State of one physical counter: running value, holding register, pending mark
    typedef struct packed {
        logic [REG_W-1:0] live;
        logic [REG_W-1:0] hold;
        logic             pend;
    } slice_t;

    function automatic sel_kind_e decode_page(input logic [1:0] page, input logic offset_zero);
        case (page)
            2'd0:    return offset_zero ? SEL_GLOBAL : SEL_NONE;
            2'd1:    return SEL_COUNTER;
            2'd2:    return SEL_EVCTL;
            default: return SEL_NONE;
        endcase
    endfunction

    // One counting step; halves are independent when split
    function automatic logic [REG_W-1:0] bump(input logic [REG_W-1:0] v, input logic split,
                                             input logic ev_hi, input logic ev_lo);
        if (split)
            return {v[REG_W-1:HALF_W] + HALF_W'(ev_hi), v[HALF_W-1:0] + HALF_W'(ev_lo)};
        return v + REG_W'(ev_hi);
    endfunction

    // New holding value for a write; a split write keeps the other half
    function automatic logic [REG_W-1:0] merge_write(input logic [REG_W-1:0] view,
                                                    input logic [REG_W-1:0] data,
                                                    input logic split, input logic low);
        if (!split)
            return data;
        if (low)
            return {view[REG_W-1:HALF_W], data[HALF_W-1:0]};
        return {data[HALF_W-1:0], view[HALF_W-1:0]};
    endfunction

    function automatic logic [REG_W-1:0] half_view(input logic [REG_W-1:0] v, input logic split,
                                                  input logic low);
        if (!split)
            return v;
        if (low)
            return {{HALF_W{1'b0}}, v[HALF_W-1:0]};
        return {{HALF_W{1'b0}}, v[REG_W-1:HALF_W]};
    endfunction

endpackage

// File: rtl/pcb_regs.sv
module pcb_regs
    import pcb_pkg::*;
#(
    parameter  int NUM_PHYS = 4,
    localparam int NUM_LOG  = 2 * NUM_PHYS,
    localparam int IDXW     = $clog2(NUM_LOG),
    localparam int ADDR_W   = IDXW + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  wdata,
    output sel_kind_e         kind_o,
    output logic [REG_W-1:0]  glob_o,
    output logic [REG_W-1:0]  evctl_rd_o,
    output logic              commit_o,
    output logic              cnt_wr_o
);

    localparam logic [REG_W-1:0] CTRL_MASK = REG_W'((64'd1 << (NUM_PHYS + 1)) - 64'd1);

    logic [REG_W-1:0] glob_q;
    logic [REG_W-1:0] evctl_q [NUM_LOG];
    logic [IDXW-1:0]  idx;

    assign idx    = reg_addr[IDXW-1:0];
    assign kind_o = decode_page(reg_addr[ADDR_W-1:IDXW], idx == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            glob_q <= '0;
            for (int i = 0; i < NUM_LOG; i++)
                evctl_q[i] <= '0;
        end else if (reg_wr) begin
            case (kind_o)
                SEL_GLOBAL: glob_q       <= wdata & CTRL_MASK;
                SEL_EVCTL:  evctl_q[idx] <= wdata;
                default: ;
            endcase
        end
    end

    assign glob_o     = glob_q;
    assign evctl_rd_o = evctl_q[idx];
    assign commit_o   = reg_wr && (kind_o == SEL_GLOBAL) && wdata[RUN_BIT];
    assign cnt_wr_o   = reg_wr && (kind_o == SEL_COUNTER);

endmodule

// File: rtl/pcb_slice.sv
module pcb_slice
    import pcb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             split,
    input  logic             commit,
    input  logic             wr,
    input  logic             wr_low,
    input  logic [REG_W-1:0] wdata,
    input  logic             ev_hi,
    input  logic             ev_lo,
    output slice_t           st_o,
    output logic [REG_W-1:0] view_o
);

    slice_t st_q;

    // A pending write is newer than the live count
    assign view_o = st_q.pend ? st_q.hold : st_q.live;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            if (wr) begin
                st_q.hold <= merge_write(view_o, wdata, split, wr_low);
                if (!run)
                    st_q.pend <= 1'b1;
            end
            if (commit) begin
                st_q.live <= st_q.hold;
                st_q.pend <= 1'b0;
            end else if (run) begin
                st_q.live <= bump(st_q.live, split, ev_hi, ev_lo);
            end
        end
    end

    assign st_o = st_q;

endmodule

// File: rtl/pcb_top.sv
module pcb_top
    import pcb_pkg::*;
#(
    parameter  int NUM_PHYS = 4,
    localparam int NUM_LOG  = 2 * NUM_PHYS,
    localparam int IDXW     = $clog2(NUM_LOG),
    localparam int ADDR_W   = IDXW + 2,
    localparam int BUS_W    = 2 * REG_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [BUS_W-1:0]   reg_wdata,
    output logic [BUS_W-1:0]   reg_rdata,
    input  logic [NUM_LOG-1:0] event_in
);

    localparam int PIDX_W = IDXW - 1;

    sel_kind_e                 kind_w;
    logic [REG_W-1:0]          glob_w;
    logic [REG_W-1:0]          evctl_rd_w;
    logic                      commit_w;
    logic                      cnt_wr_w;
    logic                      run_w;
    logic [PIDX_W-1:0]         phys_sel;
    logic                      low_sel;
    logic [REG_W-1:0]          wval;
    logic                      unused_low_word;
    logic [REG_W-1:0]          view_arr [NUM_PHYS];
    logic [NUM_PHYS-1:0]       pend_vec;
    logic [NUM_PHYS*REG_W-1:0] live_flat;
    logic [NUM_PHYS*REG_W-1:0] latch_flat;
    logic [REG_W-1:0]          rd_word;

    assign wval            = reg_wdata[BUS_W-1:REG_W];
    assign unused_low_word = ^reg_wdata[REG_W-1:0];
    assign phys_sel        = reg_addr[PIDX_W-1:0];
    assign low_sel         = reg_addr[PIDX_W];
    assign run_w           = glob_w[RUN_BIT];

    pcb_regs #(.NUM_PHYS(NUM_PHYS)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .wdata      (wval),
        .kind_o     (kind_w),
        .glob_o     (glob_w),
        .evctl_rd_o (evctl_rd_w),
        .commit_o   (commit_w),
        .cnt_wr_o   (cnt_wr_w)
    );

    for (genvar gp = 0; gp < NUM_PHYS; gp++) begin : g_slice
        slice_t st;
        pcb_slice u_slice (
            .clk    (clk),
            .rst    (rst),
            .run    (run_w),
            .split  (glob_w[HALF_LSB + gp]),
            .commit (commit_w),
            .wr     (cnt_wr_w && (phys_sel == PIDX_W'(gp))),
            .wr_low (low_sel),
            .wdata  (wval),
            .ev_hi  (event_in[gp]),
            .ev_lo  (event_in[gp + NUM_PHYS]),
            .st_o   (st),
            .view_o (view_arr[gp])
        );
        assign pend_vec[gp]                  = st.pend;
        assign live_flat[gp*REG_W +: REG_W]  = st.live;
        assign latch_flat[gp*REG_W +: REG_W] = st.hold;
    end

    always_comb begin
        case (kind_w)
            SEL_GLOBAL:  rd_word = glob_w;
            SEL_COUNTER: rd_word = half_view(view_arr[phys_sel], glob_w[HALF_LSB + int'(phys_sel)],
                                             low_sel);
            SEL_EVCTL:   rd_word = evctl_rd_w;
            default:     rd_word = '0;
        endcase
    end

    assign reg_rdata = {rd_word, {REG_W{1'b0}}};

endmodule

// File: rtl/pcb_chk.sv
module pcb_chk
    import pcb_pkg::*;
#(
    parameter  int NUM_PHYS = 4,
    localparam int NUM_LOG  = 2 * NUM_PHYS,
    localparam int IDXW     = $clog2(NUM_LOG),
    localparam int ADDR_W   = IDXW + 2,
    localparam int BUS_W    = 2 * REG_W
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      reg_wr,
    input logic [ADDR_W-1:0]         reg_addr,
    input logic [BUS_W-1:0]          reg_rdata,
    input logic                      run,
    input logic                      commit,
    input logic [NUM_PHYS-1:0]       pend_vec,
    input logic [NUM_PHYS*REG_W-1:0] live_flat,
    input logic [NUM_PHYS*REG_W-1:0] latch_flat
);

    localparam int PIDX_W = IDXW - 1;

    logic                cnt_wr;
    logic [NUM_PHYS-1:0] wr_mask;

    assign cnt_wr  = reg_wr && (reg_addr[ADDR_W-1:IDXW] == 2'd1);
    assign wr_mask = NUM_PHYS'(1) << reg_addr[PIDX_W-1:0];

    // R4: a counter write while stopped leaves that counter pending
    p_stopped_write_pends_r4: assert property (@(posedge clk) disable iff (rst)
        (cnt_wr && !run) |=> ((pend_vec & $past(wr_mask)) == $past(wr_mask)));

    // R5: a commit clears every pending mark
    p_commit_clears_pend_r5: assert property (@(posedge clk) disable iff (rst)
        commit |=> (pend_vec == '0));

    // R5: a commit loads the holding registers into the live counters
    p_commit_loads_r5: assert property (@(posedge clk) disable iff (rst)
        commit |=> (live_flat == $past(latch_flat)));

    // R6: live counters hold while stopped
    p_frozen_when_stopped_r6: assert property (@(posedge clk) disable iff (rst)
        (!run && !commit) |=> $stable(live_flat));

    // R8: the low bus word always reads zero
    p_low_word_zero_r8: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[REG_W-1:0] == '0);

    // R10: a counter write while running never sets a pending mark
    p_running_write_no_pend_r10: assert property (@(posedge clk) disable iff (rst)
        (cnt_wr && run && !commit) |=> $stable(pend_vec));

endmodule

bind pcb_top pcb_chk #(.NUM_PHYS(NUM_PHYS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .run        (run_w),
    .commit     (commit_w),
    .pend_vec   (pend_vec),
    .live_flat  (live_flat),
    .latch_flat (latch_flat)
);

// File: tb/tb_pcb_top.sv
module tb_pcb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_RD = 2'd1;
    localparam logic [1:0] OP_EV = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [4:0]  addr;
        logic [31:0] val;
        logic [7:0]  ev;
        logic [3:0]  n;
        logic [3:0]  req;
    } step_t;

    localparam int NSTEP = 45;
    localparam step_t STEPS [NSTEP] = '{
        '{OP_RD, 5'd0,  32'h0,        8'h00, 4'd0, 4'd1},  // R1 control zero
        '{OP_RD, 5'd8,  32'h0,        8'h00, 4'd0, 4'd1},  // R1 counter zero
        '{OP_WR, 5'd8,  32'h5,        8'h00, 4'd0, 4'd4},  // R4 stopped write
        '{OP_RD, 5'd8,  32'h5,        8'h00, 4'd0, 4'd4},  // R4 read shows holding value
        '{OP_EV, 5'd0,  32'h0,        8'h01, 4'd3, 4'd6},  // R6 events while stopped
        '{OP_WR, 5'd0,  32'h1,        8'h00, 4'd0, 4'd5},  // R5 commit, 32-bit mode
        '{OP_RD, 5'd8,  32'h5,        8'h00, 4'd0, 4'd5},  // R5 loaded value, no stray counts
        '{OP_EV, 5'd0,  32'h0,        8'h01, 4'd4, 4'd2},
        '{OP_RD, 5'd8,  32'h9,        8'h00, 4'd0, 4'd2},  // R2 counted four
        '{OP_EV, 5'd0,  32'h0,        8'h10, 4'd2, 4'd2},
        '{OP_RD, 5'd8,  32'h9,        8'h00, 4'd0, 4'd2},  // R2 low event ignored in 32-bit mode
        '{OP_WR, 5'd0,  32'h0,        8'h00, 4'd0, 4'd6},  // R6 stop
        '{OP_EV, 5'd0,  32'h0,        8'h01, 4'd3, 4'd6},
        '{OP_RD, 5'd8,  32'h9,        8'h00, 4'd0, 4'd6},  // R6 held
        '{OP_WR, 5'd0,  32'h2,        8'h00, 4'd0, 4'd7},  // R7 split counter 0
        '{OP_RD, 5'd8,  32'h0,        8'h00, 4'd0, 4'd7},  // R7 upper half
        '{OP_RD, 5'd12, 32'h9,        8'h00, 4'd0, 4'd7},  // R7 lower half
        '{OP_WR, 5'd12, 32'h0000FFFF, 8'h00, 4'd0, 4'd7},
        '{OP_WR, 5'd8,  32'h00001234, 8'h00, 4'd0, 4'd7},
        '{OP_RD, 5'd8,  32'h1234,     8'h00, 4'd0, 4'd7},  // R7 merged upper
        '{OP_RD, 5'd12, 32'hFFFF,     8'h00, 4'd0, 4'd7},  // R7 lower kept
        '{OP_WR, 5'd0,  32'h3,        8'h00, 4'd0, 4'd5},  // R5 commit split
        '{OP_EV, 5'd0,  32'h0,        8'h11, 4'd1, 4'd3},
        '{OP_RD, 5'd8,  32'h1235,     8'h00, 4'd0, 4'd3},  // R3 upper counts, no carry in
        '{OP_RD, 5'd12, 32'h0,        8'h00, 4'd0, 4'd3},  // R3 lower wrapped
        '{OP_EV, 5'd0,  32'h0,        8'h10, 4'd2, 4'd3},
        '{OP_RD, 5'd12, 32'h2,        8'h00, 4'd0, 4'd3},  // R3 lower alone
        '{OP_RD, 5'd8,  32'h1235,     8'h00, 4'd0, 4'd3},  // R3 upper untouched
        '{OP_WR, 5'd9,  32'h50,       8'h00, 4'd0, 4'd10}, // R10 running write
        '{OP_RD, 5'd9,  32'h0,        8'h00, 4'd0, 4'd10}, // R10 still live value
        '{OP_WR, 5'd0,  32'h3,        8'h00, 4'd0, 4'd10}, // R10 recommit
        '{OP_RD, 5'd9,  32'h50,       8'h00, 4'd0, 4'd10}, // R10 now visible
        '{OP_RD, 5'd8,  32'h1234,     8'h00, 4'd0, 4'd5},  // R5 every counter reloaded
        '{OP_RD, 5'd12, 32'hFFFF,     8'h00, 4'd0, 4'd5},  // R5
        '{OP_WR, 5'd0,  32'h2,        8'h00, 4'd0, 4'd2},
        '{OP_WR, 5'd10, 32'hFFFFFFFF, 8'h00, 4'd0, 4'd2},
        '{OP_WR, 5'd0,  32'h3,        8'h00, 4'd0, 4'd2},
        '{OP_EV, 5'd0,  32'h0,        8'h04, 4'd1, 4'd2},
        '{OP_RD, 5'd10, 32'h0,        8'h00, 4'd0, 4'd2},  // R2 32-bit wrap
        '{OP_WR, 5'd19, 32'hABCD0001, 8'h00, 4'd0, 4'd9},  // R9
        '{OP_RD, 5'd19, 32'hABCD0001, 8'h00, 4'd0, 4'd9},  // R9 read back
        '{OP_RD, 5'd16, 32'h0,        8'h00, 4'd0, 4'd9},  // R9 neighbour untouched
        '{OP_WR, 5'd24, 32'h0000DEAD, 8'h00, 4'd0, 4'd11}, // R11 unmapped write
        '{OP_RD, 5'd24, 32'h0,        8'h00, 4'd0, 4'd11}, // R11 unmapped read
        '{OP_RD, 5'd0,  32'h3,        8'h00, 4'd0, 4'd8}   // R8 control read back
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic [7:0]  event_in = '0;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pcb_top dut (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .event_in  (event_in)
    );

    task automatic wr_reg(input logic [4:0] a, input logic [31:0] v);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = {v, 32'hA5A5_5A5A};   // R8 low word is junk and must be ignored
        @(negedge clk);
        reg_wr    = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic rd_check(input logic [4:0] a, input logic [31:0] exp, input int req);
        reg_addr = a;
        #1;
        checks++;
        if (reg_rdata !== {exp, 32'h0}) begin
            fails++;
            $display("FAIL R%0d addr %0d: actual %h expected %h", req, a, reg_rdata, {exp, 32'h0});
        end
        @(negedge clk);
    endtask

    task automatic pulse(input logic [7:0] ev, input int n);
        event_in = ev;
        repeat (n) @(negedge clk);
        event_in = '0;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NSTEP; i++) begin
            case (STEPS[i].op)
                OP_WR:   wr_reg(STEPS[i].addr, STEPS[i].val);
                OP_RD:   rd_check(STEPS[i].addr, STEPS[i].val, int'(STEPS[i].req));
                default: pulse(STEPS[i].ev, int'(STEPS[i].n));
            endcase
        end

        // R3 and R7: split counter 1, preload only its upper half at 0xFFFF
        wr_reg(5'd0, 32'h0);
        wr_reg(5'd0, 32'h4);
        wr_reg(5'd9, 32'hFFFF);
        rd_check(5'd13, 32'h50, 7);    // R7 lower half of 0x50 kept
        wr_reg(5'd0, 32'h5);
        pulse(8'h02, 1);
        rd_check(5'd9, 32'h0, 3);      // R3 upper wrapped
        rd_check(5'd13, 32'h50, 3);    // R3 no carry into lower half

        // R1: reset in the middle of a run clears everything
        event_in = 8'hFF;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        event_in = '0;
        rd_check(5'd0, 32'h0, 1);      // R1
        rd_check(5'd9, 32'h0, 1);      // R1
        rd_check(5'd19, 32'h0, 1);     // R1

        finish_run();
    end

    initial begin
        while (cycles < WATCHDOG) begin
            @(posedge clk);
            cycles++;
        end
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        finish_run();
    end

endmodule